// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. The instruction decoder supplies an operation code, the accumulator value and a second operand. The block returns the result on the same cycle through purely combinational logic. It also raises a write-enable when that result should go back into the destination. Carry-in, half-carry and the rest of the condition state come from a flag byte held inside the block, so chained multi-byte arithmetic needs no external wiring.

The flag byte is registered. It changes on the clock edge that ends an executed operation, and each operation touches only the flags it owns. The byte has a fixed layout with constant filler bits, so a stack engine can save it to memory and restore it as one byte. A restore goes through a dedicated load port, which forces the filler bits back to their fixed values. Operand fetch and instruction decode belong to the surrounding datapath.

Top module: `acc_alu`

## Requirements
- R1: The flag byte `flags_o` has S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1. After reset it reads 0x02.
- R2: ADD (code 0) and ADC (code 1) produce acc_i + opnd_i, plus CY for ADC, and assert `result_we_o`. They set CY to the carry out of bit 7 and AC to the carry out of bit 3. Z is set when the result is zero, S equals result bit 7, and P is 1 when the result has an even number of one bits.
- R3: SUB (code 2) and SBB (code 3) produce acc_i − opnd_i, minus CY for SBB, and assert `result_we_o`. CY is set on a borrow into bit 7 and AC on a borrow out of the low nibble. S, Z and P follow the rules of R2.
- R4: AND (code 4), XOR (code 5) and OR (code 6) produce the bitwise result, assert `result_we_o`, update S, Z and P, and clear CY and AC.
- R5: CMP (code 7) sets all five flags exactly as SUB would. It holds `result_we_o` low and passes acc_i through on `result_o`.
- R6: INC (code 8) and DEC (code 9) act on opnd_i and assert `result_we_o`. They update S, Z, P and AC (carry or borrow at the nibble boundary) and leave CY unchanged.
- R7: RLC (code 10) and RRC (code 11) rotate the accumulator left or right, copying the bit shifted out into both the vacated end and CY. RAL (code 12) and RAR (code 13) shift the old CY into the vacated end and the bit shifted out into CY. All four assert `result_we_o` and change no flag other than CY.
- R8: CMA (code 14) returns the inverted accumulator with `result_we_o` high and all flags unchanged. CMC (code 15) inverts CY only, passes acc_i through and holds `result_we_o` low.
- R9: DAA (code 16) first adds 6 when the low nibble is above 9 or AC is set. AC becomes the carry out of bit 3 of that correction, and is 0 if no correction is made. It then adds 0x60 when the high nibble of the intermediate value is above 9 or CY is set. CY becomes 1 when this high correction is applied and otherwise keeps its value. S, Z and P follow the final result.
- R10: While `flag_load_i` is high, the next flag byte is `flag_data_i` with bits 5 and 3 forced to 0 and bit 1 forced to 1. A load takes priority over an executed operation in the same cycle.
- R11: The flag byte changes only on the clock edge at which `exec_i` or `flag_load_i` is high. An operation executed in one cycle sees, in the next cycle, the flags it produced.
- R12: Codes 17 to 31 return acc_i, hold `result_we_o` low and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand; target of INC/DEC |
| exec_i | input | 1 | Commit the operation's flag update at the next edge |
| flag_load_i | input | 1 | Restore the flag byte from `flag_data_i` |
| flag_data_i | input | 8 | Flag byte to restore |
| result_o | output | 8 | Combinational result |
| result_we_o | output | 1 | Result should be written to the destination |
| flags_o | output | 8 | Registered flag byte |

## Verification
`result_o` and `result_we_o` depend combinationally on the inputs and the current flag byte. The bench drives the operands on a falling edge and checks the result a short delay later, in the same cycle, before any edge. The flag byte is due one rising edge after the operation is presented with `exec_i` high, so the bench reads `flags_o` at the following falling edge. Each vector starts by loading a known flag byte one cycle before the operation, which fixes the carry-in and the flags that are expected to stay untouched.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_AND = 5'd4,
        OP_XOR = 5'd5,
        OP_OR  = 5'd6,
        OP_CMP = 5'd7,
        OP_INC = 5'd8,
        OP_DEC = 5'd9,
        OP_RLC = 5'd10,
        OP_RRC = 5'd11,
        OP_RAL = 5'd12,
        OP_RAR = 5'd13,
        OP_CMA = 5'd14,
        OP_CMC = 5'd15,
        OP_DAA = 5'd16
    } alu_op_e;

    // Bit order matters: the packed struct is the stacked byte.
    typedef struct packed {
        logic s;
        logic z;
        logic k5;
        logic ac;
        logic k3;
        logic p;
        logic k1;
        logic cy;
    } flags_t;

    typedef struct packed {
        flags_t flags;
    } state_t;

    localparam flags_t FLAGS_RESET = 8'h02;

    function automatic flags_t fix_const(input flags_t f);
        flags_t r;
        r    = f;
        r.k5 = 1'b0;
        r.k3 = 1'b0;
        r.k1 = 1'b1;
        return r;
    endfunction

    function automatic flags_t set_szp(input flags_t f, input logic [DATA_W-1:0] v);
        flags_t r;
        r   = f;
        r.s = v[DATA_W-1];
        r.z = (v == '0);
        r.p = ~^v;
        return r;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         hc_o
);
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   full;
    logic [NW:0]  low;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        c_eff  = cin_i ^ sub_i;
        full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low    = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
        sum_o  = full[W-1:0];
        cout_o = full[W] ^ sub_i;
        hc_o   = low[NW] ^ sub_i;
    end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic [W-1:0] a_i,
    input  logic         ac_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic         ac_o,
    output logic         cy_o
);
    localparam logic [NW-1:0] NIB_MAX = NW'(9);
    localparam logic [W-1:0]  LO_FIX  = W'(6);
    localparam logic [W-1:0]  HI_FIX  = LO_FIX << NW;

    logic          lo_fix;
    logic          hi_fix;
    logic [NW:0]   lo_sum;
    logic [W-1:0]  mid;

    always_comb begin
        lo_fix = (a_i[NW-1:0] > NIB_MAX) | ac_i;
        lo_sum = {1'b0, a_i[NW-1:0]} + (lo_fix ? {1'b0, LO_FIX[NW-1:0]} : '0);
        mid    = a_i + (lo_fix ? LO_FIX : '0);
        ac_o   = lo_fix & lo_sum[NW];
        hi_fix = (mid[W-1:NW] > NIB_MAX) | cy_i;
        res_o  = mid + (hi_fix ? HI_FIX : '0);
        cy_o   = hi_fix;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W  = acc_alu_pkg::DATA_W,
    parameter int NW = acc_alu_pkg::NIB_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    acc_i,
    input  logic [W-1:0]    opnd_i,
    input  logic            exec_i,
    input  logic            flag_load_i,
    input  logic [W-1:0]    flag_data_i,
    output logic [W-1:0]    result_o,
    output logic            result_we_o,
    output logic [W-1:0]    flags_o
);
    state_t  st_q, st_d;
    alu_op_e op;
    flags_t  cur;
    flags_t  nf;
    logic [W-1:0] res;
    logic         we;

    logic         as_sub, as_cin;
    logic [W-1:0] as_sum;
    logic         as_cout, as_hc;
    logic [W-1:0] id_sum;
    logic         id_cout, id_hc;
    logic [W-1:0] da_res;
    logic         da_ac, da_cy;

    assign op  = alu_op_e'(op_i);
    assign cur = st_q.flags;

    assign as_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    assign as_cin = ((op == OP_ADC) || (op == OP_SBB)) & cur.cy;

    acc_alu_addsub #(.W(W), .NW(NW)) u_arith (
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .sum_o  (as_sum),
        .cout_o (as_cout),
        .hc_o   (as_hc)
    );

    acc_alu_addsub #(.W(W), .NW(NW)) u_step (
        .a_i    (opnd_i),
        .b_i    (W'(1)),
        .cin_i  (1'b0),
        .sub_i  (op == OP_DEC),
        .sum_o  (id_sum),
        .cout_o (id_cout),
        .hc_o   (id_hc)
    );

    acc_alu_decadj #(.W(W), .NW(NW)) u_bcd (
        .a_i   (acc_i),
        .ac_i  (cur.ac),
        .cy_i  (cur.cy),
        .res_o (da_res),
        .ac_o  (da_ac),
        .cy_o  (da_cy)
    );

    always_comb begin
        st_d = st_q;
        nf   = cur;
        res  = acc_i;
        we   = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                res   = as_sum;
                we    = 1'b1;
                nf.cy = as_cout;
                nf.ac = as_hc;
                nf    = set_szp(nf, as_sum);
            end
            OP_CMP: begin
                nf.cy = as_cout;
                nf.ac = as_hc;
                nf    = set_szp(nf, as_sum);
            end
            OP_AND, OP_XOR, OP_OR: begin
                if (op == OP_AND)      res = acc_i & opnd_i;
                else if (op == OP_XOR) res = acc_i ^ opnd_i;
                else                   res = acc_i | opnd_i;
                we    = 1'b1;
                nf.cy = 1'b0;
                nf.ac = 1'b0;
                nf    = set_szp(nf, res);
            end
            OP_INC, OP_DEC: begin
                res   = id_sum;
                we    = 1'b1;
                nf.ac = id_hc;
                nf    = set_szp(nf, id_sum);
            end
            OP_RLC: begin
                res   = {acc_i[W-2:0], acc_i[W-1]};
                we    = 1'b1;
                nf.cy = acc_i[W-1];
            end
            OP_RRC: begin
                res   = {acc_i[0], acc_i[W-1:1]};
                we    = 1'b1;
                nf.cy = acc_i[0];
            end
            OP_RAL: begin
                res   = {acc_i[W-2:0], cur.cy};
                we    = 1'b1;
                nf.cy = acc_i[W-1];
            end
            OP_RAR: begin
                res   = {cur.cy, acc_i[W-1:1]};
                we    = 1'b1;
                nf.cy = acc_i[0];
            end
            OP_CMA: begin
                res = ~acc_i;
                we  = 1'b1;
            end
            OP_CMC: begin
                nf.cy = ~cur.cy;
            end
            OP_DAA: begin
                res   = da_res;
                we    = 1'b1;
                nf.cy = da_cy;
                nf.ac = da_ac;
                nf    = set_szp(nf, da_res);
            end
            default: begin
                res = acc_i;
                we  = 1'b0;
            end
        endcase

        if (flag_load_i) begin
            st_d.flags = fix_const(flags_t'(flag_data_i));
        end else if (exec_i) begin
            st_d.flags = fix_const(nf);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= FLAGS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o    = res;
    assign result_we_o = we;
    assign flags_o     = st_q.flags;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] op_i,
    input logic       exec_i,
    input logic       flag_load_i,
    input logic [7:0] flag_data_i,
    input logic [7:0] result_o,
    input logic       result_we_o,
    input logic [7:0] flags_o
);
    logic run;
    assign run = exec_i && !flag_load_i;

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && (flags_o[1] == 1'b1)); // R1

    AST_ADD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && op_i == 5'd0) |=> (flags_o[6] == ($past(result_o) == 8'h00))); // R2

    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (op_i == 5'd4 || op_i == 5'd5 || op_i == 5'd6))
        |=> (flags_o[4] == 1'b0 && flags_o[0] == 1'b0)); // R4

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd7) |-> !result_we_o); // R5

    AST_STEP_KEEP_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (op_i == 5'd8 || op_i == 5'd9)) |=> $stable(flags_o[0])); // R6

    AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && op_i >= 5'd10 && op_i <= 5'd13) |=> $stable(flags_o[7:1])); // R7

    AST_CMA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && op_i == 5'd14) |=> $stable(flags_o)); // R8

    AST_LOAD_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load_i |=> (flags_o == (($past(flag_data_i) & 8'hD5) | 8'h02))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_i && !flag_load_i) |=> $stable(flags_o)); // R11

    AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 5'd16) |-> !result_we_o); // R12
endmodule

bind acc_alu acc_alu_chk u_chk (.*);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic       exec_i = 1'b0;
    logic       flag_load_i = 1'b0;
    logic [7:0] flag_data_i = '0;
    logic [7:0] result_o;
    logic       result_we_o;
    logic [7:0] flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .exec_i(exec_i), .flag_load_i(flag_load_i), .flag_data_i(flag_data_i),
        .result_o(result_o), .result_we_o(result_we_o), .flags_o(flags_o)
    );

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] acc;
        logic [7:0] opnd;
        logic [7:0] fin;
        logic [7:0] res;
        logic       we;
        logic [7:0] fout;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  8'h3A, 8'hC6, 8'h02, 8'h00, 1'b1, 8'h57},
        '{5'd0,  8'h7F, 8'h01, 8'h02, 8'h80, 1'b1, 8'h92},
        '{5'd1,  8'h0F, 8'h00, 8'h03, 8'h10, 1'b1, 8'h12},
        '{5'd2,  8'h05, 8'h07, 8'h02, 8'hFE, 1'b1, 8'h93},
        '{5'd3,  8'h10, 8'h00, 8'h03, 8'h0F, 1'b1, 8'h16},
        '{5'd4,  8'hF0, 8'h3C, 8'h13, 8'h30, 1'b1, 8'h06},
        '{5'd5,  8'h5A, 8'h5A, 8'h03, 8'h00, 1'b1, 8'h46},
        '{5'd6,  8'h80, 8'h01, 8'h02, 8'h81, 1'b1, 8'h86},
        '{5'd7,  8'h20, 8'h20, 8'h03, 8'h20, 1'b0, 8'h46},
        '{5'd7,  8'h10, 8'h20, 8'h02, 8'h10, 1'b0, 8'h87},
        '{5'd8,  8'h00, 8'hFF, 8'h03, 8'h00, 1'b1, 8'h57},
        '{5'd9,  8'h00, 8'h00, 8'h02, 8'hFF, 1'b1, 8'h96},
        '{5'd8,  8'h00, 8'h7F, 8'h02, 8'h80, 1'b1, 8'h92},
        '{5'd10, 8'h85, 8'h00, 8'hD6, 8'h0B, 1'b1, 8'hD7},
        '{5'd11, 8'h01, 8'h00, 8'h02, 8'h80, 1'b1, 8'h03},
        '{5'd12, 8'h80, 8'h00, 8'h02, 8'h00, 1'b1, 8'h03},
        '{5'd13, 8'h02, 8'h00, 8'h03, 8'h81, 1'b1, 8'h02},
        '{5'd14, 8'h5C, 8'h00, 8'h97, 8'hA3, 1'b1, 8'h97},
        '{5'd15, 8'h12, 8'h00, 8'hD7, 8'h12, 1'b0, 8'hD6},
        '{5'd16, 8'h9B, 8'h00, 8'h02, 8'h01, 1'b1, 8'h13},
        '{5'd16, 8'h15, 8'h00, 8'h12, 8'h1B, 1'b1, 8'h06},
        '{5'd16, 8'h00, 8'h00, 8'h03, 8'h60, 1'b1, 8'h07},
        '{5'd20, 8'h33, 8'h44, 8'h57, 8'h33, 1'b0, 8'h57}
    };

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:                return "R2";
            5'd2, 5'd3:                return "R3";
            5'd4, 5'd5, 5'd6:          return "R4";
            5'd7:                      return "R5";
            5'd8, 5'd9:                return "R6";
            5'd10, 5'd11, 5'd12, 5'd13: return "R7";
            5'd14, 5'd15:              return "R8";
            5'd16:                     return "R9";
            default:                   return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic load_flags(input logic [7:0] v);
        @(negedge clk);
        exec_i      = 1'b0;
        flag_load_i = 1'b1;
        flag_data_i = v;
        @(negedge clk);
        flag_load_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset flags", flags_o, 8'h02);

        for (int i = 0; i < NV; i++) begin
            load_flags(VECS[i].fin);
            op_i   = VECS[i].op;
            acc_i  = VECS[i].acc;
            opnd_i = VECS[i].opnd;
            exec_i = 1'b1;
            #1;
            check(req_of(VECS[i].op), "result", result_o, VECS[i].res);
            check(req_of(VECS[i].op), "write enable", {7'd0, result_we_o}, {7'd0, VECS[i].we});
            @(negedge clk);
            exec_i = 1'b0;
            check(req_of(VECS[i].op), "flags", flags_o, VECS[i].fout);
        end

        // R10: constant bits forced on load
        load_flags(8'h00);
        check("R10", "load zeros", flags_o, 8'h02);
        load_flags(8'hFF);
        check("R10", "load ones", flags_o, 8'hD7);

        // R10: load wins over an executed operation in the same cycle
        @(negedge clk);
        op_i = 5'd0; acc_i = 8'h00; opnd_i = 8'h00;
        exec_i = 1'b1; flag_load_i = 1'b1; flag_data_i = 8'h80;
        @(negedge clk);
        exec_i = 1'b0; flag_load_i = 1'b0;
        check("R10", "load priority", flags_o, 8'h82);

        // R11: no exec, no load -> flags hold even with a carrying add present
        load_flags(8'h02);
        op_i = 5'd0; acc_i = 8'h3A; opnd_i = 8'hC6;
        #1;
        check("R11", "idle result", result_o, 8'h00);
        @(negedge clk);
        check("R11", "idle flags hold", flags_o, 8'h02);

        // R11: carry produced in one cycle feeds ADC in the next
        op_i = 5'd0; acc_i = 8'hFF; opnd_i = 8'h01; exec_i = 1'b1;
        @(negedge clk);
        check("R11", "carry registered", flags_o, 8'h57);
        op_i = 5'd1; acc_i = 8'h00; opnd_i = 8'h00;
        #1;
        check("R11", "adc uses registered carry", result_o, 8'h01);
        @(negedge clk);
        exec_i = 1'b0;
        check("R2", "adc flags after chain", flags_o, 8'h02);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule